// File: doc/BRIEF.md
# Configuration Cycle Translator

This block sits behind the upstream target port of a bus bridge and decides what happens to a configuration transaction once its address phase has been captured. It receives the address word, the command nibble and a write flag. It also receives the bridge's secondary and subordinate bus numbers. From these it chooses one of four outcomes:
- ignore the transaction;
- forward it downstream unchanged as a Type 1 access;
- rewrite it into a Type 0 access with a one-hot device-select line placed in the upper address bits;
- turn it into a special cycle.

The block returns the address and command that the downstream master must issue, along with a claim flag and a no-claim flag. The upstream target logic uses these flags to accept or refuse the access.

The control is a three-state machine:
- **IDLE** waits for `req_valid`. When `req_valid` is seen, the machine captures the request and takes the transition IDLE→CLASSIFY.
- **CLASSIFY** registers the decision and always takes CLASSIFY→DRIVE.
- **DRIVE** raises `out_valid` for exactly one cycle and always takes DRIVE→IDLE.

A request offered while the machine is in CLASSIFY or DRIVE is not taken.

Top module: `cfg_xlat`

## Requirements
- R1: After reset `out_valid`, `out_claim`, `out_noclaim` and `out_kind` are 0. A request sampled with `req_valid` at clock edge N gives `out_valid`=1 during the cycle after edge N+1, and the pulse lasts exactly one cycle.
- R2: A request is handled only when it is a Type 1 configuration access: `req_cmd` is 4'b1010 (config read) or 4'b1011 (config write), and `req_ad[1:0]`=2'b01. Any other request gives `out_kind`=0 (ignore) and both flags 0. Its `out_ad` and `out_cmd` equal the inputs.
- R3: A Type 1 access whose bus field `req_ad[23:16]` equals `sec_bus`, and which is not a special cycle, gives `out_kind`=2 (convert to Type 0) and `out_claim`=1. In `out_ad`, bits [10:2] (function number and register number) are kept and bits [1:0] are 00. `out_cmd` is unchanged.
- R4: In a Type 0 conversion with device field `req_ad[15:11]` in 0..15, `out_ad[31:11]` has exactly one bit set, at position 16 plus the device number.
- R5: In a Type 0 conversion with device number 16..31, `out_ad[31:11]` is all zero.
- R6: A special cycle requires all of the following:
  - `req_write`=1 and `req_cmd`=4'b1011;
  - the bus field equals `sec_bus`;
  - device 5'b11111, function 3'b111 and register number 0.
  Such an access gives `out_kind`=3, `out_cmd`=4'b0001, `out_ad` equal to `req_ad`, and `out_claim`=1. A read with the same encoding is converted to Type 0 instead.
- R7: A Type 1 access with `sec_bus` < bus ≤ `sub_bus` gives `out_kind`=1 (forward), `out_claim`=1, and `out_ad` and `out_cmd` equal to the inputs. This holds even when the access carries the special-cycle encoding.
- R8: A Type 1 access with bus < `sec_bus` or bus > `sub_bus` gives `out_kind`=0, `out_claim`=0 and `out_noclaim`=1. `out_claim` and `out_noclaim` are never both 1.
- R9: `req_valid` presented while the machine is in CLASSIFY or DRIVE is ignored. Such a request produces no extra `out_valid` pulse and does not alter the result being delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Captured address phase is present |
| req_ad | input | 32 | Captured address word |
| req_cmd | input | 4 | Captured command nibble |
| req_write | input | 1 | Access is a write |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| out_valid | output | 1 | One-cycle result strobe |
| out_kind | output | 2 | 0 ignore, 1 forward Type 1, 2 convert to Type 0, 3 special cycle |
| out_claim | output | 1 | Claim the access |
| out_noclaim | output | 1 | Type 1 access outside the bridge's bus range |
| out_ad | output | 32 | Address for the downstream master |
| out_cmd | output | 4 | Command for the downstream master |

## Verification
The assertions check the following on every cycle:
- the result strobe is a single-cycle pulse;
- the claim and no-claim flags are exclusive and consistent with the outcome kind;
- a Type 0 result carries at most one select bit, a zero device field and a 00 type field;
- a special-cycle result carries the special command;
- a forwarded result keeps the Type 1 marker.

Only the bench's scenarios can show that:
- each select bit lands at the correct position for a given device number;
- the bus-range boundaries at the secondary and subordinate numbers select the right outcome;
- a read carrying the special encoding is converted to Type 0, not to a special cycle;
- a request arriving while the machine is busy is dropped.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;
    localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
    localparam logic [3:0] CMD_SPECIAL = 4'b0001;

    typedef enum logic [1:0] {
        XK_IGNORE  = 2'd0,
        XK_FWD_T1  = 2'd1,
        XK_TO_T0   = 2'd2,
        XK_SPECIAL = 2'd3
    } xlat_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CLASSIFY = 2'd1,
        ST_DRIVE    = 2'd2
    } xlat_state_e;
endpackage

// File: rtl/cfg_idsel_gen.sv
module cfg_idsel_gen #(
    parameter int DEV_W      = 5,
    parameter int FIELD_LO   = 11,
    parameter int AD_W       = 32,
    parameter int IDSEL_BASE = 16,
    parameter int IDSEL_N    = 16
) (
    input  logic [DEV_W-1:0]         dev,
    output logic [AD_W-FIELD_LO-1:0] sel
);
    localparam int FW  = AD_W - FIELD_LO;
    localparam int OFF = IDSEL_BASE - FIELD_LO;

    for (genvar b = 0; b < FW; b++) begin : g_bit
        if (b >= OFF && b < OFF + IDSEL_N) begin : g_line
            assign sel[b] = (dev == DEV_W'(b - OFF));
        end else begin : g_zero
            assign sel[b] = 1'b0;
        end
    end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_xlat_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int BUS_W = 8
) (
    input  logic [AD_W-1:0]  ad,
    input  logic [3:0]       cmd,
    input  logic             wr,
    input  logic [BUS_W-1:0] sec,
    input  logic [BUS_W-1:0] sub,
    output xlat_kind_e       kind,
    output logic             claim,
    output logic             noclaim,
    output logic [AD_W-1:0]  nxt_ad,
    output logic [3:0]       nxt_cmd
);
    localparam int DEV_W   = 5;
    localparam int DEV_LO  = 11;
    localparam int FN_LO   = 8;
    localparam int REG_LO  = 2;
    localparam int BUS_LO  = 16;

    logic [BUS_W-1:0]       bus;
    logic [DEV_W-1:0]       dev;
    logic [2:0]             fn;
    logic [5:0]             regn;
    logic [AD_W-DEV_LO-1:0] sel;
    logic                   is_t1, bus_hit, bus_fwd, spec_enc;

    assign bus  = ad[BUS_LO +: BUS_W];
    assign dev  = ad[DEV_LO +: DEV_W];
    assign fn   = ad[FN_LO +: 3];
    assign regn = ad[REG_LO +: 6];

    cfg_idsel_gen #(
        .DEV_W(DEV_W), .FIELD_LO(DEV_LO), .AD_W(AD_W),
        .IDSEL_BASE(16), .IDSEL_N(16)
    ) u_idsel (
        .dev(dev),
        .sel(sel)
    );

    assign is_t1    = ((cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR)) && (ad[1:0] == 2'b01);
    assign bus_hit  = (bus == sec);
    assign bus_fwd  = (bus > sec) && (bus <= sub);
    assign spec_enc = wr && (cmd == CMD_CFG_WR) && (&dev) && (&fn) && (regn == '0);

    always_comb begin
        kind    = XK_IGNORE;
        claim   = 1'b0;
        noclaim = 1'b0;
        if (is_t1) begin
            if (bus_hit && spec_enc) begin
                kind  = XK_SPECIAL;
                claim = 1'b1;
            end else if (bus_hit) begin
                kind  = XK_TO_T0;
                claim = 1'b1;
            end else if (bus_fwd) begin
                kind  = XK_FWD_T1;
                claim = 1'b1;
            end else begin
                noclaim = 1'b1;
            end
        end
    end

    always_comb begin
        nxt_ad  = ad;
        nxt_cmd = cmd;
        unique case (kind)
            XK_TO_T0:   nxt_ad  = {sel, ad[DEV_LO-1:REG_LO], 2'b00};
            XK_SPECIAL: nxt_cmd = CMD_SPECIAL;
            XK_FWD_T1,
            XK_IGNORE:  ;
            default:    ;
        endcase
    end
endmodule

// File: rtl/cfg_xlat.sv
module cfg_xlat
    import cfg_xlat_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AD_W-1:0]  req_ad,
    input  logic [3:0]       req_cmd,
    input  logic             req_write,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output logic             out_valid,
    output logic [1:0]       out_kind,
    output logic             out_claim,
    output logic             out_noclaim,
    output logic [AD_W-1:0]  out_ad,
    output logic [3:0]       out_cmd
);
    xlat_state_e      state, state_nxt;
    logic [AD_W-1:0]  cap_ad;
    logic [3:0]       cap_cmd;
    logic             cap_wr;
    logic [BUS_W-1:0] cap_sec, cap_sub;

    xlat_kind_e       d_kind;
    logic             d_claim, d_noclaim;
    logic [AD_W-1:0]  d_ad;
    logic [3:0]       d_cmd;

    cfg_decode #(.AD_W(AD_W), .BUS_W(BUS_W)) u_dec (
        .ad(cap_ad), .cmd(cap_cmd), .wr(cap_wr),
        .sec(cap_sec), .sub(cap_sub),
        .kind(d_kind), .claim(d_claim), .noclaim(d_noclaim),
        .nxt_ad(d_ad), .nxt_cmd(d_cmd)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_nxt = ST_CLASSIFY;
            ST_CLASSIFY: state_nxt = ST_DRIVE;
            ST_DRIVE:    state_nxt = ST_IDLE;
            default:     state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ad  <= '0;
            cap_cmd <= '0;
            cap_wr  <= 1'b0;
            cap_sec <= '0;
            cap_sub <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            cap_ad  <= req_ad;
            cap_cmd <= req_cmd;
            cap_wr  <= req_write;
            cap_sec <= sec_bus;
            cap_sub <= sub_bus;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_kind    <= XK_IGNORE;
            out_claim   <= 1'b0;
            out_noclaim <= 1'b0;
            out_ad      <= '0;
            out_cmd     <= '0;
        end else if (state == ST_CLASSIFY) begin
            out_kind    <= d_kind;
            out_claim   <= d_claim;
            out_noclaim <= d_noclaim;
            out_ad      <= d_ad;
            out_cmd     <= d_cmd;
        end
    end

    assign out_valid = (state == ST_DRIVE);
endmodule

// File: rtl/cfg_xlat_chk.sv
module cfg_xlat_chk #(
    parameter int AD_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            out_valid,
    input logic [1:0]      out_kind,
    input logic            out_claim,
    input logic            out_noclaim,
    input logic [AD_W-1:0] out_ad,
    input logic [3:0]      out_cmd
);
    assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_claim_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_claim == (out_kind != 2'd0)));

    assert_type0_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd2) |->
            ($countones(out_ad[AD_W-1:16]) <= 1 && out_ad[15:11] == 5'd0 && out_ad[1:0] == 2'b00));

    assert_special_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd3) |-> (out_cmd == 4'b0001 && out_ad[1:0] == 2'b01));

    assert_fwd_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd1) |-> (out_ad[1:0] == 2'b01));

    assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_claim && out_noclaim));
endmodule

bind cfg_xlat cfg_xlat_chk #(.AD_W(AD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_kind(out_kind),
    .out_claim(out_claim), .out_noclaim(out_noclaim), .out_ad(out_ad), .out_cmd(out_cmd)
);

// File: tb/tb_cfg_xlat.sv
`timescale 1ns/1ps
module tb_cfg_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ad = '0;
    logic [3:0]  req_cmd = '0;
    logic        req_write = 1'b0;
    logic [7:0]  sec_bus = '0, sub_bus = '0;
    logic        out_valid, out_claim, out_noclaim;
    logic [1:0]  out_kind;
    logic [31:0] out_ad;
    logic [3:0]  out_cmd;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cfg_xlat dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ad(req_ad),
        .req_cmd(req_cmd), .req_write(req_write), .sec_bus(sec_bus), .sub_bus(sub_bus),
        .out_valid(out_valid), .out_kind(out_kind), .out_claim(out_claim),
        .out_noclaim(out_noclaim), .out_ad(out_ad), .out_cmd(out_cmd)
    );

    // {ad, cmd, wr, sec, sub, exp_kind, exp_noclaim, exp_ad, exp_cmd}
    localparam int NV = 16;
    localparam logic [91:0] VECS [0:NV-1] = '{
        {32'h0002_1941, 4'hA, 1'b0, 8'h02, 8'h05, 2'd2, 1'b0, 32'h0008_0140, 4'hA}, // R3 R4 dev3
        {32'h0002_0005, 4'hB, 1'b1, 8'h02, 8'h05, 2'd2, 1'b0, 32'h0001_0004, 4'hB}, // R4 dev0
        {32'h0002_7FFD, 4'hA, 1'b0, 8'h02, 8'h05, 2'd2, 1'b0, 32'h8000_07FC, 4'hA}, // R4 dev15
        {32'h0002_820D, 4'hA, 1'b0, 8'h02, 8'h05, 2'd2, 1'b0, 32'h0000_020C, 4'hA}, // R5 dev16
        {32'h0002_FF01, 4'hB, 1'b1, 8'h02, 8'h05, 2'd3, 1'b0, 32'h0002_FF01, 4'h1}, // R6 special
        {32'h0002_FF01, 4'hA, 1'b0, 8'h02, 8'h05, 2'd2, 1'b0, 32'h0000_0700, 4'hA}, // R6 read -> T0
        {32'h0002_FF05, 4'hB, 1'b1, 8'h02, 8'h05, 2'd2, 1'b0, 32'h0000_0704, 4'hB}, // R6 reg1 -> T0
        {32'h0003_1941, 4'hA, 1'b0, 8'h02, 8'h05, 2'd1, 1'b0, 32'h0003_1941, 4'hA}, // R7 sec+1
        {32'h0005_0805, 4'hB, 1'b1, 8'h02, 8'h05, 2'd1, 1'b0, 32'h0005_0805, 4'hB}, // R7 = sub
        {32'h0006_0801, 4'hA, 1'b0, 8'h02, 8'h05, 2'd0, 1'b1, 32'h0006_0801, 4'hA}, // R8 above
        {32'h0001_0801, 4'hA, 1'b0, 8'h02, 8'h05, 2'd0, 1'b1, 32'h0001_0801, 4'hA}, // R8 below
        {32'h0002_1940, 4'hA, 1'b0, 8'h02, 8'h05, 2'd0, 1'b0, 32'h0002_1940, 4'hA}, // R2 type0 in
        {32'h0002_1941, 4'h6, 1'b0, 8'h02, 8'h05, 2'd0, 1'b0, 32'h0002_1941, 4'h6}, // R2 mem read
        {32'h0002_1943, 4'hA, 1'b0, 8'h02, 8'h05, 2'd0, 1'b0, 32'h0002_1943, 4'hA}, // R2 ad=11
        {32'h0003_FF01, 4'hB, 1'b1, 8'h02, 8'h05, 2'd1, 1'b0, 32'h0003_FF01, 4'hB}, // R7 special enc fwd
        {32'h0007_4001, 4'hA, 1'b0, 8'h07, 8'h07, 2'd2, 1'b0, 32'h0100_0000, 4'hA}  // R4 dev8
    };

    function automatic string tag_of(input logic [1:0] k, input logic nc);
        case (k)
            2'd1:    return "R7";
            2'd2:    return "R3 R4 R5";
            2'd3:    return "R6";
            default: return nc ? "R8" : "R2";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] ad, input logic [3:0] cmd, input logic wr,
                        input logic [7:0] sec, input logic [7:0] sub);
        @(negedge clk);
        req_ad = ad; req_cmd = cmd; req_write = wr; sec_bus = sec; sub_bus = sub;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "out_valid", 32'(out_valid), 32'd0);
        check("R1", "out_kind", 32'(out_kind), 32'd0);
        check("R1", "flags", 32'({out_claim, out_noclaim}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle valid", 32'(out_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [91:0] v;
            string t;
            v = VECS[i];
            t = tag_of(v[38:37], v[36]);
            send(v[91:60], v[59:56], v[55], v[54:47], v[46:39]);
            check("R1", "valid", 32'(out_valid), 32'd1);
            check(t, "kind", 32'(out_kind), 32'(v[38:37]));
            check(t, "claim", 32'(out_claim), 32'(v[38:37] != 2'd0));
            check(t, "noclaim", 32'(out_noclaim), 32'(v[36]));
            check(t, "ad", out_ad, v[35:4]);
            check(t, "cmd", 32'(out_cmd), 32'(v[3:0]));
            @(negedge clk);
            check("R1", "pulse end", 32'(out_valid), 32'd0);
        end

        // R9: request held while busy is dropped
        @(negedge clk);
        req_ad = 32'h0003_1941; req_cmd = 4'hA; req_write = 1'b0;
        sec_bus = 8'h02; sub_bus = 8'h05; req_valid = 1'b1;
        @(negedge clk);
        req_ad = 32'h0006_0801;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "valid", 32'(out_valid), 32'd1);
        check("R9", "kind kept", 32'(out_kind), 32'd1);
        check("R9", "ad kept", out_ad, 32'h0003_1941);
        begin
            int pulses = 0;
            for (int c = 0; c < 5; c++) begin
                @(negedge clk);
                if (out_valid) pulses++;
            end
            check("R9", "extra pulses", 32'(pulses), 32'd0);
        end

        // R1 reset mid-flight clears outputs
        send(32'h0002_1941, 4'hA, 1'b0, 8'h02, 8'h05);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "reset valid", 32'(out_valid), 32'd0);
        check("R1", "reset kind", 32'(out_kind), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule